// File: doc/BRIEF.md
# Processor-Side Interrupt Priority Filter

This block sits between an interrupt distributor and one processor core. Each cycle the distributor offers its best pending candidate: an identifier, an 8-bit priority (lower value means more urgent) and a group bit. The block decides whether to raise the processor's interrupt request. Two tests decide this. The candidate must be more urgent than a programmable priority mask. Its group priority must also be strictly more urgent than the group priority of the interrupt the core is already running. A programmable binary point splits each priority into a group part, which decides preemption, and a subpriority part, which never does.

Software uses a small register port. It programs the mask, two binary points, and a control word holding the interface enable, the per-group enables and a shared-binary-point bit. Reading the acknowledge address takes the candidate: the read returns its identifier and pushes its priority onto a running-priority stack. Writing the end-of-interrupt address with an identifier pops that stack. The block also strobes the identifier back to the distributor on acknowledge and on end-of-interrupt. Only the upper `PRIO_BITS` bits of any priority are implemented.

Top module: `cpuif_prio_filter`

## Requirements
- R1: After reset the block holds these values. `irq_o`, `ack_pulse_o` and `eoi_pulse_o` are 0. The mask (address 0) reads 8'hF8, which is all implemented bits set. Both binary points (address 1 for group 0, address 2 for group 1) read 0. The control word (address 3) reads 0. The running priority (address 6) reads 8'hFF.
- R2: With the default PRIO_BITS=5, the low 3 bits of a written mask are discarded and read as 0. The low 3 bits of a candidate priority are ignored.
- R3: A candidate can be signalled only when its truncated priority is numerically less than the mask. An equal priority is not signalled.
- R4: Control word bit 0 enables the interface, bit 1 enables group 0 and bit 2 enables group 1. A candidate is signalled only if bit 0 and the enable bit for its group (`cand_grp_i`: 0 or 1) are both set.
- R5: With binary point b, the group priority is the priority with bits [b-1:0] cleared. When the stack is empty, any candidate that passes R3 and R4 is signalled. Otherwise the candidate's group priority must be strictly less than that of the stack top. Subpriority alone never preempts.
- R6: Group 0 candidates use binary point 0. Group 1 candidates use binary point 1, unless control bit 3 (shared binary point) is set, in which case they use binary point 0.
- R7: A read of address 4 while the candidate qualifies returns its identifier. It pushes the truncated priority, which then reads at address 6, and pulses `ack_pulse_o` for one cycle with `ack_id_o` set to the identifier.
- R8: A read of address 4 while nothing qualifies returns 1023. It pushes nothing and raises no acknowledge pulse.
- R9: A write of an identifier to address 5 pops the stack top and pulses `eoi_pulse_o` with `eoi_id_o` set to that identifier. On an empty stack the write changes nothing and raises no pulse.
- R10: The stack holds 4 entries (STACK_DEPTH). While it is full, nothing is signalled and nothing can be acknowledged.
- R11: `irq_o` is the registered qualification result. It follows a change of candidate one clock later and a register write two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | ID_W | Candidate identifier |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_grp_i | input | 1 | Candidate group (0 or 1) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, registered, held between reads |
| irq_o | output | 1 | Interrupt request to the core |
| ack_pulse_o | output | 1 | One-cycle acknowledge strobe to the distributor |
| ack_id_o | output | ID_W | Identifier acknowledged |
| eoi_pulse_o | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_id_o | output | ID_W | Identifier being ended |

## Verification
Every output of the block is registered. Read data, the acknowledge and end-of-interrupt strobes, and `irq_o` for a new candidate are all due on the first rising edge after the stimulus. `irq_o` after a register write is due one edge later, because the written value must first land in its register. The bench drives inputs on falling edges and samples read data and strobes on the falling edge that follows the capturing rising edge. Before it samples `irq_o`, it lets at least two rising edges pass after the last write or candidate change. For this reason no sample lands on an edge where the value is still moving.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

  localparam int unsigned PRIO_W = 8;

  typedef enum logic [2:0] {
    ADDR_MASK = 3'd0,
    ADDR_BP0  = 3'd1,
    ADDR_BP1  = 3'd2,
    ADDR_CTRL = 3'd3,
    ADDR_ACK  = 3'd4,
    ADDR_EOI  = 3'd5,
    ADDR_RUN  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic shared_bp;
    logic g1_en;
    logic g0_en;
    logic if_en;
  } ctrl_t;

  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  // Clear the subpriority bits below the binary point.
  function automatic logic [PRIO_W-1:0] group_part(input logic [PRIO_W-1:0] p,
                                                   input logic [2:0] bp);
    return p & (8'hFF << bp);
  endfunction

endpackage

// File: rtl/cpuif_cfg_regs.sv
module cpuif_cfg_regs
  import cpuif_pkg::*;
#(
  parameter int unsigned PRIO_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [PRIO_W-1:0] mask,
  output logic [2:0]        bp0,
  output logic [2:0]        bp1,
  output ctrl_t             ctrl
);

  localparam logic [PRIO_W-1:0] IMPL = 8'hFF << (PRIO_W - PRIO_BITS);

  logic [PRIO_W-1:0] mask_d;
  logic [2:0]        bp0_d, bp1_d;
  ctrl_t             ctrl_d;

  always_comb begin
    mask_d = mask;
    bp0_d  = bp0;
    bp1_d  = bp1;
    ctrl_d = ctrl;
    if (wr_en) begin
      case (addr)
        ADDR_MASK: mask_d = wdata & IMPL;
        ADDR_BP0:  bp0_d  = wdata[2:0];
        ADDR_BP1:  bp1_d  = wdata[2:0];
        ADDR_CTRL: ctrl_d = ctrl_t'(wdata[3:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= IMPL;
      bp0  <= '0;
      bp1  <= '0;
      ctrl <= '0;
    end else begin
      mask <= mask_d;
      bp0  <= bp0_d;
      bp1  <= bp1_d;
      ctrl <= ctrl_d;
    end
  end

  // R2
  mask_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~IMPL) == '0);

endmodule

// File: rtl/cpuif_run_stack.sv
module cpuif_run_stack
  import cpuif_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [PRIO_W-1:0] top,
  output logic              empty,
  output logic              full
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     count_q, count_d;
  logic [PRIO_W-1:0] entry_q [DEPTH];

  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));
  assign top   = empty ? IDLE_PRIO : entry_q[count_q - 1'b1];

  always_comb begin
    count_d = count_q;
    if (push && !full)       count_d = count_q + 1'b1;
    else if (pop && !empty)  count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic load;
    assign load = push && !full && (count_q == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    entry_q[g] <= IDLE_PRIO;
      else if (load) entry_q[g] <= push_prio;
    end
  end

  // R10
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R9
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/cpuif_qualify.sv
module cpuif_qualify
  import cpuif_pkg::*;
#(
  parameter int unsigned PRIO_BITS = 5
) (
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              cand_grp,
  input  logic [PRIO_W-1:0] mask,
  input  logic [2:0]        bp0,
  input  logic [2:0]        bp1,
  input  ctrl_t             ctrl,
  input  logic [PRIO_W-1:0] run_top,
  input  logic              run_empty,
  input  logic              run_full,
  output logic [PRIO_W-1:0] cand_trunc,
  output logic              fire
);

  localparam logic [PRIO_W-1:0] IMPL = 8'hFF << (PRIO_W - PRIO_BITS);

  logic       grp_on, below_mask, preempts;
  logic [2:0] bp_sel;

  assign cand_trunc = cand_prio & IMPL;
  assign grp_on     = ctrl.if_en && (cand_grp ? ctrl.g1_en : ctrl.g0_en);
  assign bp_sel     = (cand_grp && !ctrl.shared_bp) ? bp1 : bp0;
  assign below_mask = cand_trunc < mask;
  assign preempts   = run_empty ||
                      (group_part(cand_trunc, bp_sel) < group_part(run_top, bp_sel));
  assign fire       = cand_valid && grp_on && below_mask && preempts && !run_full;

endmodule

// File: rtl/cpuif_prio_filter.sv
module cpuif_prio_filter
  import cpuif_pkg::*;
#(
  parameter int unsigned PRIO_BITS   = 5,
  parameter int unsigned STACK_DEPTH = 4,
  parameter int unsigned ID_W        = 10,
  parameter int unsigned DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [7:0]        cand_prio_i,
  input  logic              cand_grp_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              ack_pulse_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_pulse_o,
  output logic [ID_W-1:0]   eoi_id_o
);

  localparam logic [ID_W-1:0] SPURIOUS = '1;

  logic [PRIO_W-1:0] mask, run_top, cand_trunc;
  logic [2:0]        bp0, bp1;
  ctrl_t             ctrl;
  logic              run_empty, run_full, fire;
  logic              ack_rd, eoi_wr, push, pop;
  logic [DATA_W-1:0] rdata_sel, rdata_d, rdata_q;
  logic [ID_W-1:0]   ack_id_d, ack_id_q, eoi_id_d, eoi_id_q;
  logic              irq_q, ack_q, eoi_q;

  cpuif_cfg_regs #(.PRIO_BITS(PRIO_BITS)) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_i),
    .addr  (reg_addr_i),
    .wdata (reg_wdata_i[7:0]),
    .mask  (mask),
    .bp0   (bp0),
    .bp1   (bp1),
    .ctrl  (ctrl)
  );

  cpuif_qualify #(.PRIO_BITS(PRIO_BITS)) qual_i (
    .cand_valid (cand_valid_i),
    .cand_prio  (cand_prio_i),
    .cand_grp   (cand_grp_i),
    .mask       (mask),
    .bp0        (bp0),
    .bp1        (bp1),
    .ctrl       (ctrl),
    .run_top    (run_top),
    .run_empty  (run_empty),
    .run_full   (run_full),
    .cand_trunc (cand_trunc),
    .fire       (fire)
  );

  cpuif_run_stack #(.DEPTH(STACK_DEPTH)) stack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_prio (cand_trunc),
    .top       (run_top),
    .empty     (run_empty),
    .full      (run_full)
  );

  assign ack_rd = reg_rd_i && (reg_addr_i == ADDR_ACK);
  assign eoi_wr = reg_wr_i && (reg_addr_i == ADDR_EOI);
  assign push   = ack_rd && fire;
  assign pop    = eoi_wr && !run_empty;

  always_comb begin
    case (reg_addr_i)
      ADDR_MASK: rdata_sel = DATA_W'(mask);
      ADDR_BP0:  rdata_sel = DATA_W'(bp0);
      ADDR_BP1:  rdata_sel = DATA_W'(bp1);
      ADDR_CTRL: rdata_sel = DATA_W'(ctrl);
      ADDR_ACK:  rdata_sel = DATA_W'(fire ? cand_id_i : SPURIOUS);
      ADDR_RUN:  rdata_sel = DATA_W'(run_top);
      default:   rdata_sel = '0;
    endcase
    rdata_d  = reg_rd_i ? rdata_sel : rdata_q;
    ack_id_d = push ? cand_id_i : ack_id_q;
    eoi_id_d = pop ? reg_wdata_i[ID_W-1:0] : eoi_id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      irq_q    <= 1'b0;
      ack_q    <= 1'b0;
      eoi_q    <= 1'b0;
      ack_id_q <= '0;
      eoi_id_q <= '0;
    end else begin
      rdata_q  <= rdata_d;
      irq_q    <= fire;
      ack_q    <= push;
      eoi_q    <= pop;
      ack_id_q <= ack_id_d;
      eoi_id_q <= eoi_id_d;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign ack_pulse_o = ack_q;
  assign ack_id_o    = ack_id_q;
  assign eoi_pulse_o = eoi_q;
  assign eoi_id_o    = eoi_id_q;

  // R7
  ack_id_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse_o |-> (reg_rdata_o == DATA_W'(ack_id_o)));
  // R8
  spurious_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !fire) |=> (!ack_pulse_o && reg_rdata_o == DATA_W'(SPURIOUS)));
  // R9
  eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse_o |-> $past(reg_wr_i && reg_addr_i == ADDR_EOI));
  // R3
  irq_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cand_valid_i && (cand_trunc < mask)));

endmodule

// File: tb/cpuif_prio_filter_tb.sv
module cpuif_prio_filter_tb_top;

  localparam int ID_W = 10;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cand_valid = 1'b0;
  logic [ID_W-1:0] cand_id = '0;
  logic [7:0]    cand_prio = '0;
  logic          cand_grp = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq, ack_pulse, eoi_pulse;
  logic [ID_W-1:0] ack_id, eoi_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpuif_prio_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .cand_grp_i(cand_grp),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .ack_pulse_o(ack_pulse), .ack_id_o(ack_id),
    .eoi_pulse_o(eoi_pulse), .eoi_id_o(eoi_id)
  );

  typedef struct packed {
    logic [3:0] ctrl;
    logic [7:0] mask;
    logic [2:0] bp0;
    logic [2:0] bp1;
    logic       runv;
    logic [7:0] run;
    logic       grp;
    logic [7:0] prio;
    logic       exp;
  } vec_t;

  // ctrl: bit0 interface, bit1 group0, bit2 group1, bit3 shared binary point
  localparam vec_t VECS [15] = '{
    '{4'h7, 8'hF8, 3'd0, 3'd0, 1'b0, 8'h00, 1'b1, 8'hA0, 1'b1},  // R3 default prio passes
    '{4'h7, 8'hA0, 3'd0, 3'd0, 1'b0, 8'h00, 1'b1, 8'hA0, 1'b0},  // R3 equal blocked
    '{4'h7, 8'hA0, 3'd0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h98, 1'b1},  // R3 below
    '{4'h7, 8'hA0, 3'd0, 3'd0, 1'b0, 8'h00, 1'b1, 8'hA7, 1'b0},  // R2 low bits dropped
    '{4'h3, 8'hF8, 3'd0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h40, 1'b0},  // R4 group1 off
    '{4'h6, 8'hF8, 3'd0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h40, 1'b0},  // R4 interface off
    '{4'h3, 8'hF8, 3'd0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h40, 1'b1},  // R4 group0 on
    '{4'h7, 8'hF8, 3'd0, 3'd0, 1'b1, 8'h80, 1'b1, 8'h78, 1'b1},  // R5 preempt
    '{4'h7, 8'hF8, 3'd0, 3'd4, 1'b1, 8'h88, 1'b1, 8'h80, 1'b0},  // R5 subprio only
    '{4'h7, 8'hF8, 3'd0, 3'd3, 1'b1, 8'h88, 1'b1, 8'h80, 1'b1},  // R5 finer split
    '{4'hF, 8'hF8, 3'd4, 3'd0, 1'b1, 8'h88, 1'b1, 8'h80, 1'b0},  // R6 shared bp
    '{4'h7, 8'hF8, 3'd4, 3'd0, 1'b1, 8'h88, 1'b1, 8'h80, 1'b1},  // R6 own bp1
    '{4'h7, 8'hF8, 3'd0, 3'd4, 1'b1, 8'h88, 1'b0, 8'h80, 1'b1},  // R6 group0 uses bp0
    '{4'h7, 8'hF8, 3'd7, 3'd0, 1'b1, 8'hC8, 1'b0, 8'h90, 1'b0},  // R5 bp7 same group
    '{4'h7, 8'hF8, 3'd0, 3'd7, 1'b0, 8'h00, 1'b1, 8'hF0, 1'b1}   // R5 idle always
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic drain();
    cand_valid = 1'b0;
    for (int k = 0; k < 4; k++) wr(3'd5, 16'd0);
  endtask

  task automatic present(input logic [7:0] p, input logic g, input logic [ID_W-1:0] id);
    @(negedge clk);
    cand_valid = 1'b1; cand_prio = p; cand_grp = g; cand_id = id;
  endtask

  logic [DW-1:0] d;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 ack", ack_pulse, 0);
    chk("R1 eoi", eoi_pulse, 0);
    rd(3'd0, d); chk("R1 mask", d, 16'hF8);
    rd(3'd1, d); chk("R1 bp0", d, 0);
    rd(3'd2, d); chk("R1 bp1", d, 0);
    rd(3'd3, d); chk("R1 ctrl", d, 0);
    rd(3'd6, d); chk("R1 run", d, 16'hFF);

    // R2 mask write truncation
    wr(3'd0, 16'h000F); rd(3'd0, d); chk("R2 mask 0F", d, 16'h08);
    wr(3'd0, 16'h00FF); rd(3'd0, d); chk("R2 mask FF", d, 16'hF8);

    // Vector table: R2..R6, R11 (irq sampled two edges after last change)
    for (int i = 0; i < 15; i++) begin
      drain();
      wr(3'd3, 16'(VECS[i].ctrl));
      wr(3'd1, 16'(VECS[i].bp0));
      wr(3'd2, 16'(VECS[i].bp1));
      wr(3'd0, 16'hF8);
      if (VECS[i].runv) begin
        present(VECS[i].run, VECS[i].grp, 10'd100);
        rd(3'd4, d);
        chk("R7 setup ack", d, 100);
      end
      cand_valid = 1'b0;
      wr(3'd0, 16'(VECS[i].mask));
      present(VECS[i].prio, VECS[i].grp, 10'(i + 1));
      settle();
      if (irq != VECS[i].exp)
        $display("vector %0d", i);
      chk("R3-R6 vector irq R11", irq, int'(VECS[i].exp));
    end

    // R7 acknowledge and strobe
    drain();
    wr(3'd3, 16'h7); wr(3'd0, 16'hF8); wr(3'd1, 16'h0);
    present(8'hA5, 1'b0, 10'd321);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd4;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R7 ack data", reg_rdata, 321);
    chk("R7 ack pulse", ack_pulse, 1);
    chk("R7 ack id", ack_id, 321);
    @(negedge clk);
    chk("R7 pulse single", ack_pulse, 0);
    rd(3'd6, d); chk("R7 running prio", d, 16'hA0);

    // R8 spurious: same-group candidate cannot preempt
    present(8'hA0, 1'b0, 10'd77);
    rd(3'd4, d); chk("R8 spurious id", d, 1023);
    chk("R8 no ack pulse", ack_pulse, 0);
    rd(3'd6, d); chk("R8 run unchanged", d, 16'hA0);

    // R9 EOI pop and strobe
    cand_valid = 1'b0;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 16'd321;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 eoi pulse", eoi_pulse, 1);
    chk("R9 eoi id", eoi_id, 321);
    rd(3'd6, d); chk("R9 run idle", d, 16'hFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 16'd55;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 empty eoi no pulse", eoi_pulse, 0);
    chk("R9 empty eoi id kept", eoi_id, 321);

    // R10 stack full
    present(8'hC0, 1'b0, 10'd1); rd(3'd4, d); chk("R10 push1", d, 1);
    present(8'h80, 1'b0, 10'd2); rd(3'd4, d); chk("R10 push2", d, 2);
    present(8'h40, 1'b0, 10'd3); rd(3'd4, d); chk("R10 push3", d, 3);
    present(8'h20, 1'b0, 10'd4); rd(3'd4, d); chk("R10 push4", d, 4);
    present(8'h08, 1'b0, 10'd5);
    settle();
    chk("R10 full no irq", irq, 0);
    rd(3'd4, d); chk("R10 full spurious", d, 1023);
    rd(3'd6, d); chk("R10 top kept", d, 16'h20);
    wr(3'd5, 16'd4);
    settle();
    chk("R10 irq after pop", irq, 1);
    rd(3'd6, d); chk("R10 top after pop", d, 16'h40);

    // R11 candidate change latency: irq drops one edge after valid falls
    @(negedge clk);
    cand_valid = 1'b0;
    @(negedge clk);
    chk("R11 irq follows candidate", irq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule